// File: doc/BRIEF.md
# Trigger Timestamp Unit with Sync Clear

This block keeps a time counter that advances once per sample clock and, at every accepted trigger, freezes a timestamp made of the current count with the trigger's two-bit fine-phase code appended below it. The fine-phase code comes from an external time-to-digital front end and gives a resolution of a quarter sample period. The frozen word is held on the output with a valid flag until the record-header logic takes it.

A sync pulse from outside, passed through a two-flop synchronizer and rising-edge detected, can restart the counter. Several units fed by the same sync line therefore share one time origin. A control register selects whether triggers are accepted and whether sync pulses are obeyed. A second address clears the sticky overflow flag, which records that a trigger overwrote a timestamp nobody had taken.

Top module: `tts_top`

## Requirements
- R1: After reset the counter is 0. It advances by exactly one per clock, and a trigger accepted in a cycle records the count of that cycle in bits [TS_W-1:FRAC_W] of `ts_word`.
- R2: A trigger strobe sampled high while the unit is armed raises `ts_valid` after the next clock edge. `ts_word` then holds {count, trig_phase}, with the phase code in bits [FRAC_W-1:0]. Exactly one word is produced per accepted trigger.
- R3: `ts_overflow` sets and stays set when an accepted trigger arrives while `ts_valid` is high and `ts_take` is low. The new word replaces the old one. Writing 1 to bit 0 at address 1 clears the flag, but a setting event in the same cycle wins.
- R4: With the sync-clear enable set, a rising edge on `sync_in` that is first sampled at clock edge k makes the cycle after edge k+1 read as time 0. A trigger in that cycle records count 0, and the following cycle reads 1.
- R5: With the sync-clear enable clear, sync edges have no effect and the count runs on uninterrupted.
- R6: While the arm bit is clear, trigger strobes produce no word, leave `ts_valid` low and never set the overflow flag.
- R7: `ts_take` sampled high with `ts_valid` high and no accepted trigger lowers `ts_valid` after the next edge. `ts_word` is unchanged.
- R8: A trigger in every clock cycle, each taken in the same cycle it is presented, produces every word with no overflow.
- R9: The count wraps from all ones to zero.
- R10: After reset, `ts_valid`, `ts_overflow` and `ts_word` are 0, and the arm and sync-clear enable bits are both 0.
- R11: Only a rising edge of the synchronized sync input clears the count. A sync level held high clears it once.
- R12: Register address 0 holds the arm bit in bit 0 and the sync-clear enable in bit 1. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | External sync level, not yet synchronized |
| trig_strobe | input | 1 | One-cycle trigger event |
| trig_phase | input | FRAC_W | Fine-phase code of the trigger |
| ts_take | input | 1 | Header logic consumes the held word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0: control, 1: overflow clear |
| reg_wdata | input | 2 | Register write data |
| ts_word | output | INT_W+FRAC_W | Held timestamp {count, phase} |
| ts_valid | output | 1 | Held timestamp not yet consumed |
| ts_overflow | output | 1 | Sticky: unconsumed timestamp overwritten |

## Verification
The bench builds the unit with a 10-bit integer field and the default 2-bit fraction. With that width, the counter wraps many times inside a few thousand cycles, so the all-ones to zero rollover is checked during both directed and random runs. The narrow width leaves the synchronizer depth and the edge-cycle timing unchanged, so the coincidence of sync clear and trigger is checked exactly as it happens at full width.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int CTRL_W = 2;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_OVF_CLR = 1'b1;

  typedef struct packed {
    logic clr_en;
    logic arm;
  } tts_ctrl_t;
endpackage

// File: rtl/tts_sync_edge.sv
module tts_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/tts_time_counter.sv
module tts_time_counter #(
  parameter int INT_W = 62
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [INT_W-1:0] cnt_q,
  output logic [INT_W-1:0] time_now
);
  // the clearing cycle itself is time zero, so the next cycle is one
  assign time_now = clear ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clear) cnt_q <= INT_W'(1);
    else            cnt_q <= cnt_q + INT_W'(1);
  end
endmodule

// File: rtl/tts_regs.sv
module tts_regs
  import tts_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output tts_ctrl_t         ctrl,
  output logic              ovf_clr
);
  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= '0;
    else if (reg_we && reg_addr == ADDR_CTRL)
      ctrl <= '{clr_en: reg_wdata[1], arm: reg_wdata[0]};
  end

  assign ovf_clr = reg_we && (reg_addr == ADDR_OVF_CLR) && reg_wdata[0];
endmodule

// File: rtl/tts_capture.sv
module tts_capture #(
  parameter int INT_W  = 62,
  parameter int FRAC_W = 2,
  localparam int TS_W  = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_acc,
  input  logic [INT_W-1:0]  time_now,
  input  logic [FRAC_W-1:0] phase,
  input  logic              take,
  input  logic              ovf_clr,
  output logic [TS_W-1:0]   word_q,
  output logic              valid_q,
  output logic              ovf_q
);
  logic ovf_set;
  assign ovf_set = trig_acc && valid_q && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      if (trig_acc) begin
        word_q  <= {time_now, phase};
        valid_q <= 1'b1;
      end else if (take) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tts_top.sv
module tts_top
  import tts_pkg::*;
#(
  parameter int INT_W       = 62,
  parameter int FRAC_W      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int TS_W       = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic              trig_strobe,
  input  logic [FRAC_W-1:0] trig_phase,
  input  logic              ts_take,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [TS_W-1:0]   ts_word,
  output logic              ts_valid,
  output logic              ts_overflow
);
  tts_ctrl_t        ctrl;
  logic             arm_en, clr_en, ovf_clr;
  logic             sync_hit, cnt_clear, trig_acc;
  logic [INT_W-1:0] cnt_q, time_now;

  tts_regs u_regs (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata,
    .ctrl, .ovf_clr
  );

  assign arm_en = ctrl.arm;
  assign clr_en = ctrl.clr_en;

  tts_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst, .async_in(sync_in), .rise(sync_hit)
  );

  assign cnt_clear = sync_hit & clr_en;

  tts_time_counter #(.INT_W(INT_W)) u_cnt (
    .clk, .rst, .clear(cnt_clear), .cnt_q, .time_now
  );

  assign trig_acc = trig_strobe & arm_en;

  tts_capture #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cap (
    .clk, .rst, .trig_acc, .time_now, .phase(trig_phase),
    .take(ts_take), .ovf_clr,
    .word_q(ts_word), .valid_q(ts_valid), .ovf_q(ts_overflow)
  );
endmodule

// File: rtl/tts_checker.sv
module tts_checker #(
  parameter int INT_W = 62
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_strobe,
  input logic             ts_take,
  input logic             ts_valid,
  input logic             ts_overflow,
  input logic             arm_en,
  input logic             clr_en,
  input logic             sync_hit,
  input logic             ovf_clr,
  input logic [INT_W-1:0] cnt_q
);
  // R1 and R9: steady step of one, wrapping modulo the width
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    !(sync_hit && clr_en) |=> cnt_q == $past(cnt_q) + INT_W'(1));

  p_sync_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (sync_hit && clr_en) |=> cnt_q == INT_W'(1));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (trig_strobe && arm_en) |=> ts_valid);

  p_overflow_set_r3: assert property (@(posedge clk) disable iff (rst)
    (trig_strobe && arm_en && ts_valid && !ts_take) |=> ts_overflow);

  p_overflow_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ts_overflow && !ovf_clr) |=> ts_overflow);

  p_no_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (!arm_en && !ts_valid) |=> !ts_valid);

  p_take_r7: assert property (@(posedge clk) disable iff (rst)
    (ts_valid && ts_take && !(trig_strobe && arm_en)) |=> !ts_valid);
endmodule

bind tts_top tts_checker #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .trig_strobe(trig_strobe), .ts_take(ts_take),
  .ts_valid(ts_valid), .ts_overflow(ts_overflow), .arm_en(arm_en),
  .clr_en(clr_en), .sync_hit(sync_hit), .ovf_clr(ovf_clr), .cnt_q(cnt_q)
);

// File: tb/sim_tts_top.sv
module sim_tts_top;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W  = 10;
  localparam int FRAC_W = 2;
  localparam int TS_W   = INT_W + FRAC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0, trig_strobe = 1'b0, ts_take = 1'b0;
  logic [FRAC_W-1:0] trig_phase = '0;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [1:0] reg_wdata = '0;
  logic [TS_W-1:0] ts_word;
  logic ts_valid, ts_overflow;

  always #(CLK_PERIOD/2) clk = ~clk;

  tts_top #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
    .clk, .rst, .sync_in, .trig_strobe, .trig_phase, .ts_take,
    .reg_we, .reg_addr, .reg_wdata, .ts_word, .ts_valid, .ts_overflow
  );

  // reference model built from the requirements
  logic [INT_W-1:0] m_cnt;
  logic m_s1, m_s2, m_s3, m_arm, m_clr_en, m_valid, m_ovf;
  logic [TS_W-1:0] m_word;
  int n_chk = 0, n_fail = 0;
  string cur_tag = "R10";
  bit done = 0;

  task automatic check(input string tag, input logic [TS_W-1:0] act, input logic [TS_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic hit, acc, set;
    logic [INT_W-1:0] tnow;
    if (rst) begin
      m_cnt = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_arm = 0; m_clr_en = 0;
      m_valid = 0; m_ovf = 0; m_word = '0;
      return;
    end
    hit  = m_s2 & ~m_s3 & m_clr_en;
    tnow = hit ? '0 : m_cnt;
    acc  = trig_strobe & m_arm;
    set  = acc & m_valid & ~ts_take;
    if (set) m_ovf = 1;
    else if (reg_we && reg_addr && reg_wdata[0]) m_ovf = 0;
    if (acc) begin
      m_valid = 1;
      m_word = {tnow, trig_phase};
    end else if (ts_take) m_valid = 0;
    m_cnt = hit ? INT_W'(1) : m_cnt + INT_W'(1);
    if (reg_we && !reg_addr) begin
      m_arm = reg_wdata[0];
      m_clr_en = reg_wdata[1];
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(cur_tag, TS_W'(ts_valid), TS_W'(m_valid));
    check(cur_tag, TS_W'(ts_overflow), TS_W'(m_ovf));
    if (m_valid) check(cur_tag, ts_word, m_word);
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 0;
  endtask

  task automatic report();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2: actual hung expected completion (watchdog)");
      report();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R10: reset state
    check("R10", ts_word, '0);
    check("R10", TS_W'(ts_valid), '0);
    check("R10", TS_W'(ts_overflow), '0);

    // R6: unarmed triggers ignored
    cur_tag = "R6";
    trig_strobe = 1;
    repeat (3) cyc();
    trig_strobe = 0;
    check("R6", TS_W'(ts_valid), '0);

    // R12: arm on, sync clear off
    cur_tag = "R12";
    wr(1'b0, 2'b01);

    // R1/R2: triggers with various phases
    cur_tag = "R2";
    for (int i = 0; i < 4; i++) begin
      trig_strobe = 1; trig_phase = FRAC_W'(i);
      cyc();
      trig_strobe = 0; ts_take = 1;
      cur_tag = "R1";
      cyc();
      ts_take = 0;
      repeat (i) cyc();
    end

    // R7: take clears valid, word holds
    cur_tag = "R7";
    trig_strobe = 1; trig_phase = 2'd3;
    cyc();
    trig_strobe = 0;
    begin
      logic [TS_W-1:0] held;
      held = ts_word;
      ts_take = 1;
      cyc();
      ts_take = 0;
      check("R7", TS_W'(ts_valid), '0);
      check("R7", ts_word, held);
    end

    // R3: overflow set, sticky, cleared by write
    cur_tag = "R3";
    trig_strobe = 1; trig_phase = 2'd1;
    cyc(); cyc();
    trig_strobe = 0;
    check("R3", TS_W'(ts_overflow), TS_W'(1));
    repeat (3) cyc();
    check("R3", TS_W'(ts_overflow), TS_W'(1));
    wr(1'b1, 2'b01);
    check("R3", TS_W'(ts_overflow), '0);
    ts_take = 1; cyc(); ts_take = 0;

    // R5: sync ignored while clear enable off
    cur_tag = "R5";
    sync_in = 1;
    repeat (4) cyc();
    sync_in = 0;
    trig_strobe = 1; cyc(); trig_strobe = 0;
    ts_take = 1; cyc(); ts_take = 0;

    // R4: sync clear coincident with trigger
    cur_tag = "R4";
    wr(1'b0, 2'b11);
    repeat (3) cyc();
    sync_in = 1;
    cyc(); cyc();
    trig_strobe = 1; trig_phase = 2'd2; ts_take = 1;
    cyc();
    check("R4", ts_word, {INT_W'(0), 2'd2});
    trig_phase = 2'd0;
    cyc();
    check("R4", ts_word, {INT_W'(1), 2'd0});
    trig_strobe = 0; ts_take = 0;

    // R11: held-high sync clears once
    cur_tag = "R11";
    repeat (10) begin
      trig_strobe = 1; ts_take = 1;
      cyc();
    end
    check("R11", ts_word, {INT_W'(11), 2'd0});
    sync_in = 0;

    // R8 and R9: trigger every cycle across a wrap
    cur_tag = "R8";
    for (int i = 0; i < 1100; i++) begin
      trig_phase = FRAC_W'($urandom_range(0, 3));
      if (i == 1050) cur_tag = "R9";
      cyc();
    end
    check("R8", TS_W'(ts_overflow), '0);
    trig_strobe = 0; ts_take = 0;

    // random mix
    cur_tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      trig_strobe = ($urandom_range(0, 99) < 40);
      ts_take = ($urandom_range(0, 99) < 60);
      trig_phase = FRAC_W'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 3) sync_in = ~sync_in;
      reg_we = ($urandom_range(0, 99) < 2);
      reg_addr = 1'($urandom_range(0, 1));
      reg_wdata = {1'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0)};
      cyc();
    end
    reg_we = 0;
    report();
  end
endmodule